// File: doc/BRIEF.md
# Instruction Decoder and Control-Word Generator

This block turns one 16-bit instruction word into the full set of datapath steering signals for a small three-address, register-to-register processor. The signals are the destination, A and B register addresses, the constant/register operand select, the ALU function code, the result-source select, the register write enable and the memory write enable. It also produces a constant word sign-extended to the datapath width, a jump strobe, a branch strobe and the branch condition code. The instruction layout keeps every field at a fixed bit position in all formats. The register addresses therefore pass straight through. The ALU function code is copied from the opcode, and only the category in the top three bits needs real decoding.

The decode is combinational. It is followed by a single output register, so the control word for an instruction presented before a clock edge appears on the outputs after that edge. Reset clears the register to a word that writes nothing and strobes nothing. Sequencing of the program counter, the datapath itself and multi-cycle instructions lie outside the block.

Top module: `instr_ctl_decoder`

## Requirements
- R1: While rst_n is low, all outputs are held at zero, so wr_o, mw_o, jump_o and branch_o are all 0.
- R2: One clock edge after an instruction is sampled, dst_o equals instruction bits 8-6, srca_o equals bits 5-3 and srcb_o equals bits 2-0, in every category.
- R3: Category 000 (bits 15-13) is a register ALU operation: opsel_o=0, ressel_o=0, wr_o=1, mw_o=0, fs_o = {0, bits 12-9}.
- R4: Category 100 is an immediate ALU operation: opsel_o=1, ressel_o=0, wr_o=1, mw_o=0, fs_o = {0, bits 12-9}.
- R5: Category 101 is an immediate shift: opsel_o=1, ressel_o=0, wr_o=1, mw_o=0, fs_o = {1, bits 12-9}.
- R6: Category 001 is a memory load: opsel_o=0, ressel_o=1, wr_o=1, mw_o=0, fs_o=0.
- R7: Category 010 is a memory store: opsel_o=0, ressel_o=0, wr_o=0, mw_o=1, fs_o=0.
- R8: Category 011 loads a constant through the pass-B ALU function: opsel_o=1, ressel_o=0, wr_o=1, mw_o=0, fs_o=10000.
- R9: Category 110 is a branch: branch_o=1, br_type_o = bits 11-9, wr_o=0, mw_o=0, opsel_o=0, fs_o=0. Bit 12 has no effect on any output.
- R10: Category 111 is a jump: jump_o=1, br_type_o=0, wr_o=0, mw_o=0, opsel_o=0, fs_o=0.
- R11: For categories 000 to 101, const_o is bits 2-0 read as a two's-complement number and sign-extended to DATA_W bits.
- R12: For categories 110 and 111, const_o is the 6-bit offset {bits 8-6, bits 2-0} read as two's complement (-32 to +31) and sign-extended to DATA_W bits.
- R13: jump_o is 1 only for category 111 and branch_o only for category 110. br_type_o is 0 outside category 110, and wr_o and mw_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 16 | Instruction word to decode |
| dst_o | output | 3 | Destination register address |
| srca_o | output | 3 | A-side source register address |
| srcb_o | output | 3 | B-side source register address |
| opsel_o | output | 1 | B operand source: 0 register, 1 constant |
| fs_o | output | 5 | ALU function select |
| ressel_o | output | 1 | Write-back source: 0 ALU, 1 memory |
| wr_o | output | 1 | Register file write enable |
| mw_o | output | 1 | Memory write enable |
| const_o | output | DATA_W | Sign-extended constant or PC offset |
| jump_o | output | 1 | Unconditional jump strobe |
| branch_o | output | 1 | Conditional branch strobe |
| br_type_o | output | 3 | Branch condition code |

## Verification
The assertions assume that instr_i carries known values at each sampling edge and that reset is applied from time zero for at least one edge. Each output is checked against the instruction sampled one edge earlier. Every one of the 128 opcodes is a legal input, so there is no forbidden input space. The stimulus still sweeps all eight categories with all sixteen low opcode codes, so the assertions see every arm of the decode. Directed words add the extreme positive and negative immediates and offsets, and a branch pair that differs only in bit 12. Instructions are applied only while reset is released, one word per cycle.

// File: rtl/ictl_pkg.sv
package ictl_pkg;

    localparam int INSTR_W = 16;
    localparam int REG_W   = 3;
    localparam int CAT_W   = 3;
    localparam int FUNC_W  = 4;
    localparam int FS_W    = FUNC_W + 1;
    localparam int BT_W    = 3;
    localparam int IMM_W   = 3;
    localparam int OFFS_W  = 2 * REG_W;

    // field positions fixed by the instruction layout
    localparam int CAT_LSB  = INSTR_W - CAT_W;
    localparam int FUNC_LSB = CAT_LSB - FUNC_W;
    localparam int DST_LSB  = 2 * REG_W;
    localparam int SRCA_LSB = REG_W;
    localparam int SRCB_LSB = 0;

    localparam logic [FS_W-1:0] FS_PASS_B = 5'b10000;

    typedef enum logic [CAT_W-1:0] {
        CAT_REG_ALU = 3'b000,
        CAT_LOAD    = 3'b001,
        CAT_STORE   = 3'b010,
        CAT_LDCONST = 3'b011,
        CAT_IMM_ALU = 3'b100,
        CAT_IMM_SHF = 3'b101,
        CAT_BRANCH  = 3'b110,
        CAT_JUMP    = 3'b111
    } cat_e;

    typedef struct packed {
        logic [REG_W-1:0]  dst;
        logic [REG_W-1:0]  srca;
        logic [REG_W-1:0]  srcb;
        logic [CAT_W-1:0]  cat;
        logic [FUNC_W-1:0] func;
        logic [IMM_W-1:0]  imm;
        logic [OFFS_W-1:0] offs;
    } fields_t;

    typedef struct packed {
        logic            opsel;
        logic            ressel;
        logic            wr;
        logic            mw;
        logic            jump;
        logic            branch;
        logic [FS_W-1:0] fs;
        logic [BT_W-1:0] btype;
        logic            use_offs;
    } ctrl_t;

endpackage

// File: rtl/ictl_field_split.sv
module ictl_field_split
    import ictl_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output fields_t            fields_o
);

    always_comb begin
        fields_o      = '0;
        fields_o.dst  = instr_i[DST_LSB  +: REG_W];
        fields_o.srca = instr_i[SRCA_LSB +: REG_W];
        fields_o.srcb = instr_i[SRCB_LSB +: REG_W];
        fields_o.cat  = instr_i[CAT_LSB  +: CAT_W];
        fields_o.func = instr_i[FUNC_LSB +: FUNC_W];
        fields_o.imm  = instr_i[SRCB_LSB +: IMM_W];
        // offset is split around the A-source field: high part in the dst slot
        fields_o.offs = {instr_i[DST_LSB +: REG_W], instr_i[SRCB_LSB +: REG_W]};
    end

endmodule

// File: rtl/ictl_cat_decode.sv
module ictl_cat_decode
    import ictl_pkg::*;
(
    input  logic [CAT_W-1:0]  cat_i,
    input  logic [FUNC_W-1:0] func_i,
    output ctrl_t             ctrl_o
);

    always_comb begin
        ctrl_o = '0;
        unique case (cat_e'(cat_i))
            CAT_REG_ALU: begin
                ctrl_o.wr = 1'b1;
                ctrl_o.fs = {1'b0, func_i};
            end
            CAT_LOAD: begin
                ctrl_o.ressel = 1'b1;
                ctrl_o.wr     = 1'b1;
            end
            CAT_STORE: begin
                ctrl_o.mw = 1'b1;
            end
            CAT_LDCONST: begin
                ctrl_o.opsel = 1'b1;
                ctrl_o.wr    = 1'b1;
                ctrl_o.fs    = FS_PASS_B;
            end
            CAT_IMM_ALU: begin
                ctrl_o.opsel = 1'b1;
                ctrl_o.wr    = 1'b1;
                ctrl_o.fs    = {1'b0, func_i};
            end
            CAT_IMM_SHF: begin
                ctrl_o.opsel = 1'b1;
                ctrl_o.wr    = 1'b1;
                ctrl_o.fs    = {1'b1, func_i};
            end
            CAT_BRANCH: begin
                ctrl_o.branch   = 1'b1;
                ctrl_o.btype    = func_i[BT_W-1:0];
                ctrl_o.use_offs = 1'b1;
            end
            CAT_JUMP: begin
                ctrl_o.jump     = 1'b1;
                ctrl_o.use_offs = 1'b1;
            end
            default: ctrl_o = '0;
        endcase
    end

endmodule

// File: rtl/ictl_const_gen.sv
module ictl_const_gen
    import ictl_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [OFFS_W-1:0] offs_i,
    input  logic              use_offs_i,
    output logic [DATA_W-1:0] const_o
);

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] offs_ext;

    generate
        if (DATA_W >= OFFS_W) begin : g_wide
            assign imm_ext  = DATA_W'($signed(imm_i));
            assign offs_ext = DATA_W'($signed(offs_i));
        end else begin : g_narrow
            assign imm_ext  = DATA_W'($signed(imm_i));
            assign offs_ext = offs_i[DATA_W-1:0];
        end
    endgenerate

    assign const_o = use_offs_i ? offs_ext : imm_ext;

endmodule

// File: rtl/instr_ctl_decoder.sv
module instr_ctl_decoder
    import ictl_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        instr_i,
    output logic [2:0]         dst_o,
    output logic [2:0]         srca_o,
    output logic [2:0]         srcb_o,
    output logic               opsel_o,
    output logic [4:0]         fs_o,
    output logic               ressel_o,
    output logic               wr_o,
    output logic               mw_o,
    output logic [DATA_W-1:0]  const_o,
    output logic               jump_o,
    output logic               branch_o,
    output logic [2:0]         br_type_o
);

    typedef struct packed {
        logic [REG_W-1:0]  dst;
        logic [REG_W-1:0]  srca;
        logic [REG_W-1:0]  srcb;
        ctrl_t             ctl;
        logic [DATA_W-1:0] k;
    } word_t;

    fields_t           fld;
    ctrl_t             ctl;
    logic [DATA_W-1:0] k;
    word_t             word_d;
    word_t             word_q;

    ictl_field_split u_split (
        .instr_i  (instr_i),
        .fields_o (fld)
    );

    ictl_cat_decode u_cat (
        .cat_i  (fld.cat),
        .func_i (fld.func),
        .ctrl_o (ctl)
    );

    ictl_const_gen #(.DATA_W(DATA_W)) u_const (
        .imm_i      (fld.imm),
        .offs_i     (fld.offs),
        .use_offs_i (ctl.use_offs),
        .const_o    (k)
    );

    always_comb begin
        word_d      = '0;
        word_d.dst  = fld.dst;
        word_d.srca = fld.srca;
        word_d.srcb = fld.srcb;
        word_d.ctl  = ctl;
        word_d.k    = k;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign dst_o     = word_q.dst;
    assign srca_o    = word_q.srca;
    assign srcb_o    = word_q.srcb;
    assign opsel_o   = word_q.ctl.opsel;
    assign fs_o      = word_q.ctl.fs;
    assign ressel_o  = word_q.ctl.ressel;
    assign wr_o      = word_q.ctl.wr;
    assign mw_o      = word_q.ctl.mw;
    assign const_o   = word_q.k;
    assign jump_o    = word_q.ctl.jump;
    assign branch_o  = word_q.ctl.branch;
    assign br_type_o = word_q.ctl.btype;

endmodule

// File: rtl/ictl_checker.sv
module ictl_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       instr_i,
    input logic [2:0]        dst_o,
    input logic [2:0]        srca_o,
    input logic [2:0]        srcb_o,
    input logic              opsel_o,
    input logic [4:0]        fs_o,
    input logic              ressel_o,
    input logic              wr_o,
    input logic              mw_o,
    input logic [DATA_W-1:0] const_o,
    input logic              jump_o,
    input logic              branch_o,
    input logic [2:0]        br_type_o
);

    AST_FIELD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> {dst_o, srca_o, srcb_o} == $past(instr_i[8:0])); // R2

    AST_REG_ALU: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(instr_i[15:13]) == 3'b000 |->
        !opsel_o && !ressel_o && wr_o && !mw_o && fs_o == {1'b0, $past(instr_i[12:9])}); // R3

    AST_IMM_ALU: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(instr_i[15:13]) == 3'b100 |->
        opsel_o && wr_o && !mw_o && fs_o == {1'b0, $past(instr_i[12:9])}); // R4

    AST_SHIFT_FS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(instr_i[15:13]) == 3'b101 |->
        opsel_o && wr_o && fs_o == {1'b1, $past(instr_i[12:9])}); // R5

    AST_LOAD_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(instr_i[15:13]) == 3'b001 |->
        ressel_o && wr_o && !mw_o && !opsel_o); // R6

    AST_STORE_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(instr_i[15:13]) == 3'b010 |->
        !opsel_o && !wr_o && mw_o); // R7

    AST_PASS_B: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(instr_i[15:13]) == 3'b011 |->
        opsel_o && wr_o && fs_o == 5'b10000); // R8

    AST_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(instr_i[15:13]) == 3'b110 |->
        branch_o && !wr_o && !mw_o && br_type_o == $past(instr_i[11:9])); // R9

    AST_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(instr_i[15:13]) == 3'b111 |->
        jump_o && !wr_o && !mw_o); // R10

    AST_IMM_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(instr_i[15:14]) != 2'b11 |->
        const_o == DATA_W'($signed($past(instr_i[2:0])))); // R11

    AST_OFFS_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(instr_i[15:14]) == 2'b11 |->
        const_o == DATA_W'($signed({$past(instr_i[8:6]), $past(instr_i[2:0])}))); // R12

    AST_NO_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({jump_o, branch_o}) && !(wr_o && mw_o)); // R13

endmodule

bind instr_ctl_decoder ictl_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr_i   (instr_i),
    .dst_o     (dst_o),
    .srca_o    (srca_o),
    .srcb_o    (srcb_o),
    .opsel_o   (opsel_o),
    .fs_o      (fs_o),
    .ressel_o  (ressel_o),
    .wr_o      (wr_o),
    .mw_o      (mw_o),
    .const_o   (const_o),
    .jump_o    (jump_o),
    .branch_o  (branch_o),
    .br_type_o (br_type_o)
);

// File: tb/tb_instr_ctl_decoder.sv
`timescale 1ns/1ps
module tb_instr_ctl_decoder;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   instr_i = '0;
    logic [2:0]    dst_o, srca_o, srcb_o, br_type_o;
    logic          opsel_o, ressel_o, wr_o, mw_o, jump_o, branch_o;
    logic [4:0]    fs_o;
    logic [DW-1:0] const_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    instr_ctl_decoder #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i),
        .dst_o(dst_o), .srca_o(srca_o), .srcb_o(srcb_o),
        .opsel_o(opsel_o), .fs_o(fs_o), .ressel_o(ressel_o),
        .wr_o(wr_o), .mw_o(mw_o), .const_o(const_o),
        .jump_o(jump_o), .branch_o(branch_o), .br_type_o(br_type_o)
    );

    typedef struct packed {
        logic [8:0]    regs;
        logic [3:0]    sel;    // opsel, ressel, wr, mw
        logic [4:0]    fs;
        logic [2:0]    bt;
        logic [1:0]    strb;   // jump, branch
        logic [DW-1:0] k;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    function automatic string cat_tag(input logic [2:0] c);
        case (c)
            3'b000:  return "R3";
            3'b001:  return "R6";
            3'b010:  return "R7";
            3'b011:  return "R8";
            3'b100:  return "R4";
            3'b101:  return "R5";
            3'b110:  return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic exp_t model(input logic [15:0] w);
        exp_t e;
        logic signed [2:0] im;
        logic signed [5:0] of;
        e = '0;
        im = w[2:0];
        of = {w[8:6], w[2:0]};
        e.regs = w[8:0];
        case (w[15:13])
            3'b000: begin e.sel = 4'b0010; e.fs = {1'b0, w[12:9]}; end
            3'b001: e.sel = 4'b0110;
            3'b010: e.sel = 4'b0001;
            3'b011: begin e.sel = 4'b1010; e.fs = 5'b10000; end
            3'b100: begin e.sel = 4'b1010; e.fs = {1'b0, w[12:9]}; end
            3'b101: begin e.sel = 4'b1010; e.fs = {1'b1, w[12:9]}; end
            3'b110: begin e.strb = 2'b01; e.bt = w[11:9]; end
            default: e.strb = 2'b10;
        endcase
        if (w[15:14] == 2'b11) e.k = DW'(of);
        else                   e.k = DW'(im);
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] w);
        @(negedge clk);
        instr_i = w;
        exp_q.push_back(model(w));
        tag_q.push_back(cat_tag(w[15:13]));
    endtask

    // monitor: compares one registered word per cycle after the capture edge
    initial begin
        exp_t  e;
        exp_t  a;
        string t;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = '0;
                a.regs = {dst_o, srca_o, srcb_o};
                a.sel  = {opsel_o, ressel_o, wr_o, mw_o};
                a.fs   = fs_o;
                a.bt   = br_type_o;
                a.strb = {jump_o, branch_o};
                a.k    = const_o;
                check(a.regs == e.regs, "R2", "register fields", 64'(a.regs), 64'(e.regs));
                check(a.sel == e.sel && a.fs == e.fs, t, "selects/fs",
                      64'({a.sel, a.fs}), 64'({e.sel, e.fs}));
                check(a.k == e.k, (e.strb != 0) ? "R12" : "R11", "constant",
                      64'(a.k), 64'(e.k));
                check(a.strb == e.strb && a.bt == e.bt && !(wr_o && mw_o), "R13",
                      "strobes/type", 64'({a.strb, a.bt}), 64'({e.strb, e.bt}));
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        check({wr_o, mw_o, jump_o, branch_o, fs_o, opsel_o, ressel_o} == '0 && const_o == '0,
              "R1", "reset outputs", 64'({wr_o, mw_o, jump_o, branch_o, fs_o}), 64'h0);
        instr_i = 16'hFFFF;
        @(posedge clk);
        #1;
        check({wr_o, mw_o, jump_o, branch_o} == 4'b0, "R1", "reset holds with input",
              64'({wr_o, mw_o, jump_o, branch_o}), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // every category with every low opcode code and varied fields
        for (int c = 0; c < 8; c++) begin
            for (int f = 0; f < 16; f++) begin
                drive({3'(c), 4'(f), 9'((c * 37 + f * 83 + 5) & 9'h1ff)});
            end
        end
        // branch pair differing only in bit 12 (R9)
        drive({3'b110, 1'b0, 3'b011, 9'b101_010_000});
        drive({3'b110, 1'b1, 3'b011, 9'b101_010_000});
        // extreme immediates (R11)
        drive({3'b100, 4'b0010, 9'b001_010_100});
        drive({3'b100, 4'b0010, 9'b001_010_011});
        drive({3'b011, 4'b0000, 9'b110_000_111});
        // extreme offsets (R12)
        drive({3'b111, 4'b0000, 9'b100_000_000});
        drive({3'b111, 4'b0000, 9'b011_000_111});
        drive({3'b110, 4'b0101, 9'b101_011_000});
        // back-to-back store/load (R6, R7)
        for (int i = 0; i < 6; i++) begin
            drive({(i % 2 == 0) ? 3'b010 : 3'b001, 4'(i), 9'(i * 61)});
        end
        @(negedge clk);
        instr_i = '0;
        repeat (4) @(posedge clk);
        #1;
        if (exp_q.size() != 0)
            check(1'b0, "R2", "pending results", 64'(exp_q.size()), 64'h0);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "R1", "watchdog expired", 64'h1, 64'h0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule